// File: doc/BRIEF.md
# Ownership Token Allocator

This block issues 8-bit ownership tokens so that several host threads can take turns on one shared interface. A host thread polls the assign register; each read has a side effect: it claims the first free token at or after an internal counter, marks it in a 256-entry in-use bitmap, makes it the current owner, and advances the counter. A read that returns zero means all 255 usable tokens are taken and the thread should poll again. When done, the owner writes its token back to the owner register, which frees it.

The embedded controller side sees the in-use bitmap as 32-bit words, selected by word index (token >> 5, bit token & 31). It can drop a single token's in-use bit or wipe the whole map. The block only tracks tokens; it does not guard the resource the token stands for.

Top module: `aid_alloc_top`

## Requirements
- R1: After reset the owner register reads 0, every bitmap word reads 0 and the counter holds 1, so the first assign read returns 1.
- R2: While the assign read strobe is high, the assign data shows the first token whose in-use bit is clear, searching upward from the counter and wrapping from 255 to 1; on the following edge that token's in-use bit is set and the owner register takes that token.
- R3: An assign read that finds a token sets the counter to that token plus one, with 255 followed by 1; a read that finds none advances the counter by one with the same wrap. The counter never holds 0.
- R4: With all 255 tokens in use the assign data reads 0, and the read changes neither the bitmap nor the owner register.
- R5: An assign write strobe advances the counter by one (wrapping 255 to 1) and allocates nothing; when the read strobe is high in the same cycle the write is ignored.
- R6: An owner write whose data is nonzero and equal to the owner register clears the owner register to 0 and the in-use bit of that token on the next edge.
- R7: An owner write of 0, or of a value other than the current owner, changes neither the owner register nor the bitmap.
- R8: Word w of the controller view, selected by the word-select input, carries at bit b the in-use flag of token 32*w+b; bit 0 of word 0 (token 0) always reads 0.
- R9: A single clear strobe drops the in-use bit of the given token and leaves the owner register unchanged; clearing token 0 has no effect.
- R10: A clear-all strobe zeroes every bitmap word; a token allocated in the same cycle keeps its in-use bit set.
- R11: When an allocation and a valid release happen in the same cycle, the released token's bit is cleared and the owner register takes the newly allocated token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_assign_rd | input | 1 | Host read of the assign register (allocates) |
| host_assign_wr | input | 1 | Host write of the assign register (advances counter) |
| host_assign_rdata | output | ID_W | Token returned by the assign read, 0 if none free |
| host_owner_wr | input | 1 | Host write of the owner register |
| host_owner_wdata | input | ID_W | Token written to the owner register |
| host_owner_rdata | output | ID_W | Current owner token, 0 if none |
| ec_word_sel | input | SEL_W | Bitmap word index for the controller view |
| ec_word_rdata | output | EC_W | Selected bitmap word |
| ec_clr_one | input | 1 | Clear the in-use bit of ec_clr_id |
| ec_clr_id | input | ID_W | Token to clear |
| ec_clr_all | input | 1 | Clear the whole bitmap |

## Verification
The bench fills all 255 tokens in order and then polls, so a design that wrapped the counter through 0 would hand out token 0, and one that allocated while full would move the owner. Releases are tried with 0, with a wrong token and with the right one; a design that compared loosely would drop ownership it should keep. Clear-all and release are driven in the same cycle as an allocation, where a wrong priority would lose the new token's bit or leave the old owner in place, and assign writes mixed with reads expose a counter that double-steps or fails to skip busy tokens.

// File: rtl/aid_pkg.sv
package aid_pkg;
   // Next counter value: steps by one, wraps from max_id back to 1, never 0.
   function automatic int unsigned aid_next(int unsigned cur, int unsigned max_id);
      return (cur >= max_id) ? 1 : cur + 1;
   endfunction
endpackage

// File: rtl/aid_free_search.sv
module aid_free_search #(
   parameter int ID_W   = 8,
   localparam int N_IDS  = 1 << ID_W,
   localparam int MAX_ID = N_IDS - 1
) (
   input  logic [N_IDS-1:0] busy,
   input  logic [ID_W-1:0]  start,
   output logic             hit,
   output logic [ID_W-1:0]  hit_id
);
   logic [ID_W-1:0] cand;

   // Rotating scan over tokens 1..MAX_ID beginning at the counter.
   always_comb begin
      hit    = 1'b0;
      hit_id = '0;
      cand   = start;
      for (int k = 0; k < MAX_ID; k++) begin
         if (!hit && !busy[cand]) begin
            hit    = 1'b1;
            hit_id = cand;
         end
         cand = ID_W'(aid_pkg::aid_next(32'(cand), MAX_ID));
      end
   end
endmodule

// File: rtl/aid_bitmap.sv
module aid_bitmap #(
   parameter int ID_W  = 8,
   localparam int N_IDS = 1 << ID_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [ID_W-1:0]  set_id,
   input  logic             rel_en,
   input  logic [ID_W-1:0]  rel_id,
   input  logic             clr_one,
   input  logic [ID_W-1:0]  clr_id,
   input  logic             clr_all,
   output logic [N_IDS-1:0] busy
);
   for (genvar i = 0; i < N_IDS; i++) begin : g_bit
      if (i == 0) begin : g_rsv
         // Token 0 is reserved and never marked.
         assign busy[i] = 1'b0;
      end else begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (set_en && set_id == ID_W'(i))
               q <= 1'b1;
            else if (clr_all || (clr_one && clr_id == ID_W'(i))
                     || (rel_en && rel_id == ID_W'(i)))
               q <= 1'b0;
         end
         assign busy[i] = q;
      end
   end
endmodule

// File: rtl/aid_ec_view.sv
module aid_ec_view #(
   parameter int ID_W    = 8,
   parameter int EC_W    = 32,
   localparam int N_IDS   = 1 << ID_W,
   localparam int N_WORDS = N_IDS / EC_W,
   localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic [N_IDS-1:0] busy,
   input  logic [SEL_W-1:0] sel,
   output logic [EC_W-1:0]  word
);
   logic [EC_W-1:0] words [N_WORDS];

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      assign words[w] = busy[w*EC_W +: EC_W];
   end

   if (N_WORDS == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign word = words[0];
   end else begin : g_mux
      assign word = words[sel];
   end
endmodule

// File: rtl/aid_alloc_top.sv
module aid_alloc_top #(
   parameter int ID_W    = 8,
   parameter int EC_W    = 32,
   localparam int N_IDS   = 1 << ID_W,
   localparam int MAX_ID  = N_IDS - 1,
   localparam int N_WORDS = N_IDS / EC_W,
   localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_assign_rd,
   input  logic             host_assign_wr,
   output logic [ID_W-1:0]  host_assign_rdata,
   input  logic             host_owner_wr,
   input  logic [ID_W-1:0]  host_owner_wdata,
   output logic [ID_W-1:0]  host_owner_rdata,
   input  logic [SEL_W-1:0] ec_word_sel,
   output logic [EC_W-1:0]  ec_word_rdata,
   input  logic             ec_clr_one,
   input  logic [ID_W-1:0]  ec_clr_id,
   input  logic             ec_clr_all
);
   if (ID_W < 2 || ID_W > 12) begin : g_bad_idw
      $error("aid_alloc_top: ID_W must lie in 2..12");
   end
   if (EC_W < 1 || EC_W > N_IDS || (N_IDS % EC_W) != 0) begin : g_bad_ecw
      $error("aid_alloc_top: EC_W must divide the token count");
   end

   logic [N_IDS-1:0] busy_vec;
   logic [ID_W-1:0]  cnt_q;
   logic [ID_W-1:0]  owner_q;
   logic             found;
   logic [ID_W-1:0]  found_id;
   logic             alloc_ok;
   logic             rel_hit;

   aid_free_search #(.ID_W(ID_W)) u_search (
      .busy   (busy_vec),
      .start  (cnt_q),
      .hit    (found),
      .hit_id (found_id)
   );

   assign alloc_ok          = host_assign_rd && found;
   assign host_assign_rdata = found ? found_id : '0;
   assign rel_hit           = host_owner_wr && (host_owner_wdata != '0)
                              && (host_owner_wdata == owner_q);

   aid_bitmap #(.ID_W(ID_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (alloc_ok),
      .set_id  (found_id),
      .rel_en  (rel_hit),
      .rel_id  (owner_q),
      .clr_one (ec_clr_one),
      .clr_id  (ec_clr_id),
      .clr_all (ec_clr_all),
      .busy    (busy_vec)
   );

   // Counter: a read moves it past the returned token; a write steps it once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= ID_W'(1);
      else if (host_assign_rd)
         cnt_q <= found ? ID_W'(aid_pkg::aid_next(32'(found_id), MAX_ID))
                        : ID_W'(aid_pkg::aid_next(32'(cnt_q), MAX_ID));
      else if (host_assign_wr)
         cnt_q <= ID_W'(aid_pkg::aid_next(32'(cnt_q), MAX_ID));
   end

   // Owner: a new grant outranks a release in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owner_q <= '0;
      else if (alloc_ok)
         owner_q <= found_id;
      else if (rel_hit)
         owner_q <= '0;
   end

   assign host_owner_rdata = owner_q;

   aid_ec_view #(.ID_W(ID_W), .EC_W(EC_W)) u_view (
      .busy (busy_vec),
      .sel  (ec_word_sel),
      .word (ec_word_rdata)
   );
endmodule

// File: rtl/aid_alloc_chk.sv
module aid_alloc_chk #(
   parameter int ID_W  = 8,
   localparam int N_IDS = 1 << ID_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_assign_rd,
   input logic [ID_W-1:0]  host_assign_rdata,
   input logic             host_owner_wr,
   input logic [ID_W-1:0]  host_owner_wdata,
   input logic [ID_W-1:0]  host_owner_rdata,
   input logic             ec_clr_all,
   input logic [N_IDS-1:0] busy,
   input logic [ID_W-1:0]  cnt
);
   // R2: a granted token was free when handed out
   a_r2_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
      (host_assign_rd && host_assign_rdata != '0) |-> !busy[host_assign_rdata]);

   // R2: the grant becomes the owner on the next edge
   a_r2_grant_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (host_assign_rd && host_assign_rdata != '0)
      |=> (host_owner_rdata == $past(host_assign_rdata)));

   // R3: counter never rests on the reserved token
   a_r3_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0);

   // R4: a failed poll leaves the owner alone
   a_r4_full_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (host_assign_rd && host_assign_rdata == '0 && !host_owner_wr)
      |=> $stable(host_owner_rdata));

   // R6: matching release empties the owner register
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (host_owner_wr && host_owner_wdata != '0
       && host_owner_wdata == host_owner_rdata && !host_assign_rd)
      |=> (host_owner_rdata == '0));

   // R7: zero or mismatching write leaves the owner
   a_r7_no_release: assert property (@(posedge clk) disable iff (!rst_n)
      (host_owner_wr && (host_owner_wdata == '0
       || host_owner_wdata != host_owner_rdata) && !host_assign_rd)
      |=> $stable(host_owner_rdata));

   // R8: reserved token never marked
   a_r8_token0_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[0]);

   // R10: clear-all without a grant empties the map
   a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (ec_clr_all && !(host_assign_rd && host_assign_rdata != '0))
      |=> (busy == '0));
endmodule

bind aid_alloc_top aid_alloc_chk #(.ID_W(ID_W)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .host_assign_rd    (host_assign_rd),
   .host_assign_rdata (host_assign_rdata),
   .host_owner_wr     (host_owner_wr),
   .host_owner_wdata  (host_owner_wdata),
   .host_owner_rdata  (host_owner_rdata),
   .ec_clr_all        (ec_clr_all),
   .busy              (busy_vec),
   .cnt               (cnt_q)
);

// File: tb/tb_aid_alloc_top.sv
`timescale 1ns/1ps
module tb_aid_alloc_top;
   localparam int ID_W = 8;
   localparam int EC_W = 32;
   localparam int NIDS = 256;
   localparam int NW   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_rd = 0, a_wr = 0, o_wr = 0, c1 = 0, ca = 0;
   logic [ID_W-1:0] o_wd = '0, c_id = '0;
   logic [2:0] sel = '0;
   logic [ID_W-1:0] a_rdata, o_rdata;
   logic [EC_W-1:0] w_rdata;

   always #2.5 clk = ~clk;

   aid_alloc_top #(.ID_W(ID_W), .EC_W(EC_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .host_assign_rd(a_rd), .host_assign_wr(a_wr), .host_assign_rdata(a_rdata),
      .host_owner_wr(o_wr), .host_owner_wdata(o_wd), .host_owner_rdata(o_rdata),
      .ec_word_sel(sel), .ec_word_rdata(w_rdata),
      .ec_clr_one(c1), .ec_clr_id(c_id), .ec_clr_all(ca));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Reference state
   bit m_busy [NIDS];
   int m_cnt;
   int m_own;

   function automatic int nxt(int v);
      return (v >= NIDS-1) ? 1 : v + 1;
   endfunction

   function automatic int exp_alloc();
      int c = m_cnt;
      for (int k = 0; k < NIDS-1; k++) begin
         if (!m_busy[c]) return c;
         c = nxt(c);
      end
      return 0;
   endfunction

   function automatic logic [31:0] exp_word(int w);
      logic [31:0] r;
      for (int b = 0; b < 32; b++) r[b] = m_busy[w*32+b];
      return r;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // One cycle: drive after negedge, check before posedge, then update the model.
   task automatic step(bit rd, bit wr, bit ow, int owd, int s, bit one, int cid, bit all);
      int e;
      bit rel;
      @(negedge clk);
      a_rd = rd; a_wr = wr; o_wr = ow; o_wd = ID_W'(owd);
      sel = 3'(s); c1 = one; c_id = ID_W'(cid); ca = all;
      #1;
      e = exp_alloc();
      if (rd) chk("R2/R3/R4 assign data", int'(a_rdata), e);
      chk("R6/R7/R11 owner", int'(o_rdata), m_own);
      chk("R8/R9/R10 word", int'(w_rdata), int'(exp_word(s)));
      rel = ow && owd != 0 && owd == m_own;
      @(posedge clk);
      if (all) for (int i = 0; i < NIDS; i++) m_busy[i] = 0;
      if (one && cid != 0) m_busy[cid] = 0;
      if (rel) m_busy[m_own] = 0;
      if (rd && e != 0) m_busy[e] = 1;
      if (rd && e != 0) m_own = e;
      else if (rel) m_own = 0;
      if (rd) m_cnt = (e != 0) ? nxt(e) : nxt(m_cnt);
      else if (wr) m_cnt = nxt(m_cnt);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed;
      void'($urandom(32'h5eed_a1d0));
      for (int i = 0; i < NIDS; i++) m_busy[i] = 0;
      m_cnt = 1; m_own = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, all words clear, owner 0
      for (int w = 0; w < NW; w++) step(0, 0, 0, 0, w, 0, 0, 0);
      chk("R1 first token", int'(a_rdata), 1);

      // R2 R3: fill every token in order
      for (int i = 1; i < NIDS; i++) step(1, 0, 0, 0, i / 32, 0, 0, 0);
      // R4: full, polls return 0, owner kept (255)
      step(1, 0, 0, 0, 7, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 owner after full poll", int'(o_rdata), 255);

      // R7: write 0 and a wrong token, then R6 release of 255
      step(0, 0, 1, 0, 7, 0, 0, 0);
      step(0, 0, 1, 17, 7, 0, 0, 0);
      step(0, 0, 1, 255, 7, 0, 0, 0);
      idle();
      chk("R6 owner cleared", int'(o_rdata), 0);

      // R9: clear token 7 and token 0; owner unchanged
      step(0, 0, 0, 0, 0, 1, 7, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      // R2: next read finds 7 or 255 depending on counter
      step(1, 0, 0, 0, 0, 0, 0, 0);
      // R5: assign writes step the counter; write alongside read ignored
      step(0, 1, 0, 0, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0, 1, 40, 0);
      step(1, 1, 0, 0, 1, 0, 0, 0);
      // R10: clear all with an allocation in the same cycle
      step(1, 0, 0, 0, 0, 0, 0, 1);
      for (int w = 0; w < NW; w++) step(0, 0, 0, 0, w, 0, 0, 0);
      // R11: allocate and release the current owner in the same cycle
      step(1, 0, 1, m_own, 0, 0, 0, 0);
      idle();

      // Random mix
      for (int n = 0; n < 6000; n++) begin
         int r = $urandom % 100;
         bit rd = r < 35;
         bit wr = ($urandom % 100) < 10;
         bit ow = ($urandom % 100) < 30;
         int owd = (($urandom % 4) == 0) ? int'($urandom % NIDS) : m_own;
         bit one = ($urandom % 100) < 8;
         bit all = ($urandom % 1000) < 5;
         step(rd, wr, ow, owd, int'($urandom % NW), one, int'($urandom % NIDS), all);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule